// File: doc/BRIEF.md
# Turn-Model Mesh Routing Unit

This block computes the output direction for a head flit in a router of a two-dimensional mesh. It compares the coordinates of the current node with the destination carried by the flit. It then returns the set of output ports that may be used and one preferred port among them. The five ports are Local, East, West, North and South.

A mode input selects the routing discipline. Dimension-order mode moves along X until X matches and then moves along Y, so it gives one answer only. The two adaptive modes forbid only a pair of turns, which is enough to prevent cycles of turn dependencies. In west-first mode, every westward hop must come before any other direction. In north-last mode, northward hops wait until all other movement is finished.

For the adaptive modes, the unit reports every productive port that the turn rule allows. The preferred port is the allowed port with the lowest index. The router's allocator can take the preferred port, or use the mask to pick another allowed port. Inputs are captured on a valid strobe, and the results appear after one register stage.

Top module: `mesh_turn_router`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first capture, `valid_o`, `port_o` and `allow_o` are all zero.
- R2: When `valid_i` is high at a rising clock edge, `valid_o` is high after that edge, and `port_o`/`allow_o` hold the result for the inputs sampled at that edge.
- R3: If the destination equals the current node, `allow_o` holds only the Local bit, in every mode.
- R4: Mode 0 (dimension order): if `dst_x_i > cur_x_i` the mask is East only, and if `dst_x_i < cur_x_i` it is West only. Otherwise the mask is North only when `dst_y_i > cur_y_i`, and South only when `dst_y_i < cur_y_i`.
- R5: Mode 1 (west-first): if `dst_x_i < cur_x_i`, the mask is West only.
- R6: Mode 1 with no westward distance left: the mask is the set of productive ports among East (`dst_x_i > cur_x_i`), North (`dst_y_i > cur_y_i`) and South (`dst_y_i < cur_y_i`).
- R7: Mode 2 (north-last): if `dst_x_i != cur_x_i` or `dst_y_i < cur_y_i`, the mask is the set of productive ports among East, West and South, and North is never included.
- R8: Mode 2 with only northward distance left: the mask is North only.
- R9: Port bit order is 0 Local, 1 East, 2 West, 3 North, 4 South. East means increasing X and North means increasing Y. `port_o` is one-hot and equals the lowest-index set bit of `allow_o`.
- R10: Mode 3 gives the same result as mode 0.
- R11: When `valid_i` is low at an edge, `valid_o` goes low and `port_o`/`allow_o` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Head flit coordinates present |
| mode_i | input | 2 | 0 dimension order, 1 west-first, 2 north-last, 3 as 0 |
| cur_x_i | input | 3 | Current node X |
| cur_y_i | input | 3 | Current node Y |
| dst_x_i | input | 3 | Destination X |
| dst_y_i | input | 3 | Destination Y |
| valid_o | output | 1 | Result valid |
| port_o | output | 5 | Preferred port, one-hot |
| allow_o | output | 5 | Allowed productive ports |

## Verification
Every result is due exactly one rising edge after the edge that samples `valid_i` high, because there is a single register stage between the inputs and the outputs. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, which is half a period after the capture edge. Just before the capture edge, it also confirms that `valid_o` is still low. For the hold behaviour, it drops `valid_i`, changes the coordinates, and then reads the outputs on two more falling edges to confirm they did not change.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned P_LOCAL = 0;
  localparam int unsigned P_EAST  = 1;
  localparam int unsigned P_WEST  = 2;
  localparam int unsigned P_NORTH = 3;
  localparam int unsigned P_SOUTH = 4;

  typedef logic [NUM_PORTS-1:0] port_mask_t;

  typedef enum logic [1:0] {
    MODE_XY  = 2'd0,
    MODE_WF  = 2'd1,
    MODE_NL  = 2'd2,
    MODE_RSV = 2'd3
  } route_mode_e;

  typedef struct packed {
    logic east;
    logic west;
    logic north;
    logic south;
  } route_need_t;
endpackage

// File: rtl/route_delta.sv
module route_delta
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 3
) (
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output route_need_t        need_o
);
  always_comb begin
    need_o.east  = dst_x_i > cur_x_i;
    need_o.west  = dst_x_i < cur_x_i;
    need_o.north = dst_y_i > cur_y_i;
    need_o.south = dst_y_i < cur_y_i;
  end
endmodule

// File: rtl/route_turn_mask.sv
module route_turn_mask
  import route_pkg::*;
(
  input  route_need_t need_i,
  input  logic [1:0]  mode_i,
  output port_mask_t  mask_o
);
  logic any_move;
  logic horiz;
  assign any_move = need_i.east | need_i.west | need_i.north | need_i.south;
  assign horiz    = need_i.east | need_i.west;

  always_comb begin
    mask_o = '0;
    if (!any_move) begin
      mask_o[P_LOCAL] = 1'b1;
    end else begin
      unique case (route_mode_e'(mode_i))
        MODE_WF: begin
          if (need_i.west) begin
            mask_o[P_WEST] = 1'b1;
          end else begin
            mask_o[P_EAST]  = need_i.east;
            mask_o[P_NORTH] = need_i.north;
            mask_o[P_SOUTH] = need_i.south;
          end
        end
        MODE_NL: begin
          if (horiz || need_i.south) begin
            mask_o[P_EAST]  = need_i.east;
            mask_o[P_WEST]  = need_i.west;
            mask_o[P_SOUTH] = need_i.south;
          end else begin
            mask_o[P_NORTH] = 1'b1;
          end
        end
        default: begin
          if (horiz) begin
            mask_o[P_EAST] = need_i.east;
            mask_o[P_WEST] = need_i.west;
          end else begin
            mask_o[P_NORTH] = need_i.north;
            mask_o[P_SOUTH] = need_i.south;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/route_pick_first.sv
module route_pick_first #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]   = req_i[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_i[i];
  end
endmodule

// File: rtl/mesh_turn_router.sv
module mesh_turn_router
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         mode_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output logic               valid_o,
  output logic [NUM_PORTS-1:0] port_o,
  output logic [NUM_PORTS-1:0] allow_o
);
  route_need_t need;
  port_mask_t  mask_d;
  port_mask_t  pick_d;

  route_delta #(.COORD_W(COORD_W)) u_delta (
    .cur_x_i(cur_x_i),
    .cur_y_i(cur_y_i),
    .dst_x_i(dst_x_i),
    .dst_y_i(dst_y_i),
    .need_o (need)
  );

  route_turn_mask u_mask (
    .need_i(need),
    .mode_i(mode_i),
    .mask_o(mask_d)
  );

  route_pick_first #(.N(NUM_PORTS)) u_pick (
    .req_i(mask_d),
    .gnt_o(pick_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      port_o  <= '0;
      allow_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o  <= pick_d;
        allow_o <= mask_d;
      end
    end
  end
endmodule

// File: rtl/mesh_turn_router_chk.sv
module mesh_turn_router_chk
  import route_pkg::*;
#(
  parameter int unsigned COORD_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         mode_i,
  input logic [COORD_W-1:0] cur_x_i,
  input logic [COORD_W-1:0] cur_y_i,
  input logic [COORD_W-1:0] dst_x_i,
  input logic [COORD_W-1:0] dst_y_i,
  input logic               valid_o,
  input logic [NUM_PORTS-1:0] port_o,
  input logic [NUM_PORTS-1:0] allow_o
);
  AST_PORT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(port_o) == 1) else $error("port not one-hot"); // R9

  AST_PORT_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (port_o & ~allow_o) == '0) else $error("port outside mask"); // R9

  AST_LOCAL_ON_ARRIVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((($past(cur_x_i) == $past(dst_x_i)) && ($past(cur_y_i) == $past(dst_y_i)))
                 == (allow_o == port_mask_t'(1 << P_LOCAL)))) else $error("local mismatch"); // R3

  AST_WF_WEST_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == MODE_WF && allow_o[P_WEST]) |->
      allow_o == port_mask_t'(1 << P_WEST)) else $error("west-first turn into west"); // R5

  AST_NL_NORTH_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == MODE_NL && allow_o[P_NORTH]) |->
      allow_o == port_mask_t'(1 << P_NORTH)) else $error("north-last turn out of north"); // R8

  AST_XY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(mode_i) == MODE_XY || $past(mode_i) == MODE_RSV)) |->
      $countones(allow_o) == 1) else $error("dimension order not single"); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(port_o) && $stable(allow_o))) else $error("idle changed outputs"); // R11
endmodule

bind mesh_turn_router mesh_turn_router_chk #(.COORD_W(COORD_W)) u_chk (.*);

// File: tb/mesh_turn_router_tb_top.sv
module mesh_turn_router_tb_top;
  localparam int W = 3;
  localparam int LIM = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [W-1:0] cx = '0, cy = '0, dx = '0, dy = '0;
  logic valid_o;
  logic [4:0] port_o, allow_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mesh_turn_router #(.COORD_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .cur_x_i(cx), .cur_y_i(cy), .dst_x_i(dx), .dst_y_i(dy),
    .valid_o(valid_o), .port_o(port_o), .allow_o(allow_o)
  );

  // bits: 0 L, 1 E, 2 W, 3 N, 4 S
  function automatic logic [4:0] exp_mask(int m, int a, int b, int c, int d);
    logic e, w, n, s;
    e = c > a; w = c < a; n = d > b; s = d < b;
    if (!(e | w | n | s)) return 5'b00001;
    if (m == 1) begin
      if (w) return 5'b00100;
      return {s, n, 1'b0, e, 1'b0};
    end
    if (m == 2) begin
      if (e | w | s) return {s, 1'b0, w, e, 1'b0};
      return 5'b01000;
    end
    if (e | w) return {2'b00, w, e, 1'b0};
    return {s, n, 3'b000};
  endfunction

  function automatic logic [4:0] lowest(logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return 5'(1 << i);
    return 5'b0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(int m, int a, int b, int c, int d);
    @(negedge clk);
    mode_i = 2'(m); cx = W'(a); cy = W'(b); dx = W'(c); dy = W'(d);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(valid_o), 0);
    check("R1 port", 32'(port_o), 0);
    check("R1 allow", 32'(allow_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid after release", 32'(valid_o), 0);
    check("R1 allow after release", 32'(allow_o), 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    mode_i = 2'd0; cx = 3'd1; cy = 3'd1; dx = 3'd5; dy = 3'd1; valid_i = 1'b1;
    #5;
    check("R2 not yet valid", 32'(valid_o), 0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2 valid", 32'(valid_o), 1);
    check("R2 allow east", 32'(allow_o), 32'h02);
  endtask

  task automatic t_corners();
    apply(1, 3, 3, 5, 6);
    check("R6 wf east+north", 32'(allow_o), 32'h0A);
    check("R9 wf pref east", 32'(port_o), 32'h02);
    apply(1, 3, 3, 3, 0);
    check("R6 wf south only", 32'(allow_o), 32'h10);
    apply(2, 4, 4, 1, 7);
    check("R7 nl west no north", 32'(allow_o), 32'h04);
    apply(2, 4, 4, 4, 7);
    check("R8 nl north only", 32'(allow_o), 32'h08);
    apply(1, 7, 0, 0, 7);
    check("R5 wf west only", 32'(allow_o), 32'h04);
    apply(3, 2, 2, 2, 2);
    check("R3 local mode3", 32'(allow_o), 32'h01);
    apply(3, 0, 7, 0, 0);
    check("R10 mode3 south", 32'(allow_o), 32'h10);
  endtask

  task automatic t_sweep(int m);
    for (int a = 0; a < LIM; a++)
      for (int b = 0; b < LIM; b++)
        for (int c = 0; c < LIM; c++)
          for (int d = 0; d < LIM; d++) begin
            string tag;
            logic [4:0] em;
            em = exp_mask(m, a, b, c, d);
            if (a == c && b == d) tag = "R3";
            else if (m == 1) tag = (c < a) ? "R5" : "R6";
            else if (m == 2) tag = (c != a || d < b) ? "R7" : "R8";
            else if (m == 3) tag = "R10";
            else tag = "R4";
            apply(m, a, b, c, d);
            check(tag, 32'(allow_o), 32'(em));
            check("R9", 32'(port_o), 32'(lowest(em)));
          end
  endtask

  task automatic t_hold();
    logic [4:0] keep_a, keep_p;
    apply(2, 6, 1, 0, 0);
    keep_a = allow_o; keep_p = port_o;
    check("R11 setup allow", 32'(keep_a), 32'h14);
    mode_i = 2'd1; cx = 3'd0; cy = 3'd0; dx = 3'd7; dy = 3'd7;
    @(negedge clk);
    check("R11 valid low", 32'(valid_o), 0);
    check("R11 allow held", 32'(allow_o), 32'(keep_a));
    @(negedge clk);
    check("R11 port held", 32'(port_o), 32'(keep_p));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #35;
    t_reset();
    t_latency();
    t_corners();
    for (int m = 0; m < 4; m++) t_sweep(m);
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule